// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken, using two pieces of information together: a few low-order bits of the branch address, and the pattern of outcomes of the most recent branches anywhere in the program. The address bits pick a group of 2-bit saturating counters. The global outcome pattern then picks one counter inside that group, and the upper bit of that counter is the prediction. This lets one branch hold a different prediction for each recent-history context. No tag is stored, so branches whose selected address bits match share counters.

A front-end stage presents a PC on the predict port and gets a registered taken/not-taken answer one cycle later. When the branch resolves, the back end presents the same PC and the actual outcome on the update port. Only the counter that the prediction used is moved one step toward the outcome, and the outcome is then shifted into the global history. At most one branch resolves per cycle. After reset the block walks the whole table once to load every counter with weakly not-taken. It ignores both ports until that walk completes.

Top module: `corr_branch_pred`

## Requirements
- R1: A prediction request accepted on a clock edge produces `pred_out_valid` high with `pred_taken` in the following cycle. The answer reflects every update accepted on an edge at least two edges before the request edge.
- R2: Each counter takes one of four values: 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken, 11 strongly taken. A taken update increments it and a not-taken update decrements it, saturating at 11 and 00. The prediction is bit 1 of the counter.
- R3: From a strong state, a single opposite outcome does not change the prediction. A second consecutive opposite outcome flips it.
- R4: With the default parameters the counter index is {PC[9:2], history[1:0]}, with the history in the low bits. PC bits [1:0] and bits above 9 play no part, so PCs that differ only there share counters. Different history values select different counters for the same PC.
- R5: The global history register is 0 after reset. Every accepted update shifts it left by one, with the new outcome (taken = 1) entering at bit 0. Nothing else changes it.
- R6: An update indexes its counter with the history value as it stood before that update's outcome is shifted in.
- R7: An update changes only the one counter it indexes. Counters in other sets, or under other history values, keep their values.
- R8: While reset is high and for 2^(SET_BITS+HIST_LEN) cycles after it falls, `init_done` is low and the block loads every counter with 01. During that time both request ports are ignored and `pred_out_valid` stays low. After that, `init_done` stays high until the next reset.
- R9: Updates to the same counter on consecutive cycles are each applied in full, with none lost.
- R10: With HIST_LEN = 0 the block is a plain per-address table of 2-bit counters: a branch's prediction depends only on its own updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | output | 1 | High once the counter table has been initialised |
| pred_valid | input | 1 | Prediction request |
| pred_pc | input | PC_W | Branch address to predict |
| pred_out_valid | output | 1 | Prediction result valid (one cycle after request) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench drives a single counter into saturation five times over, which catches a design that wraps from 11 to 00. It then sends one and then two opposite outcomes to find a design that lacks hysteresis. It trains a branch under one history value and reads it under another. It also checks whether the design indexes the update with the post-shift history, which would leave the trained counter untouched and give the wrong answer when the history returns. A back-to-back pair of updates to one counter exposes a read-modify-write path without forwarding, because such a design loses one increment. Requests made during the initialisation walk, PCs that alias in their high or low bits, a per-address configuration with no history, and a long random mix checked against a reference model cover the rest.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // Saturating step toward the resolved direction.
  function automatic ctr_t ctr_next(input ctr_t c, input logic taken);
    if (taken) return (c == CTR_ST) ? CTR_ST : ctr_t'(c + 2'd1);
    else       return (c == CTR_SNT) ? CTR_SNT : ctr_t'(c - 2'd1);
  endfunction

  function automatic logic ctr_dir(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/cbp_history.sv
module cbp_history #(
  parameter int HIST_LEN = 2,
  localparam int HW = (HIST_LEN > 0) ? HIST_LEN : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          outcome,
  output logic [HW-1:0] hist
);

  generate
    if (HIST_LEN == 0) begin : g_none
      logic unused_hist_in;
      assign unused_hist_in = ^{clk, rst, shift_en, outcome};
      assign hist = '0;
    end else begin : g_reg
      logic [HW-1:0] hist_q;

      if (HIST_LEN == 1) begin : g_one
        always_ff @(posedge clk) begin
          if (rst)           hist_q <= '0;
          else if (shift_en) hist_q <= outcome;
        end
      end else begin : g_many
        always_ff @(posedge clk) begin
          if (rst)           hist_q <= '0;
          else if (shift_en) hist_q <= {hist_q[HW-2:0], outcome};
        end

        // Older outcomes move up by one place (R5)
        assert_shift_up_R5: assert property (@(posedge clk) disable iff (rst)
          shift_en |=> hist_q[HW-1:1] == $past(hist_q[HW-2:0]));
      end

      assign hist = hist_q;

      // Newest outcome lands at bit 0 (R5)
      assert_shift_in_R5: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist_q[0] == $past(outcome));

      // History only moves on an accepted update (R5)
      assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist_q));
    end
  endgenerate

endmodule

// File: rtl/cbp_index.sv
module cbp_index #(
  parameter int PC_W     = 32,
  parameter int ADDR_LSB = 2,
  parameter int SET_BITS = 8,
  parameter int HIST_LEN = 2,
  localparam int HW    = (HIST_LEN > 0) ? HIST_LEN : 1,
  localparam int IDX_W = SET_BITS + HIST_LEN
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [HW-1:0]    hist,
  output logic [IDX_W-1:0] idx
);

  logic [SET_BITS-1:0] set_sel;
  logic unused_pc_bits;

  assign set_sel = pc[ADDR_LSB +: SET_BITS];
  assign unused_pc_bits = ^{pc[ADDR_LSB-1:0], pc[PC_W-1:ADDR_LSB+SET_BITS]};

  generate
    if (HIST_LEN == 0) begin : g_addr_only
      logic unused_hist;
      assign unused_hist = ^hist;
      assign idx = set_sel;
    end else begin : g_concat
      assign idx = {set_sel, hist};
    end
  endgenerate

endmodule

// File: rtl/cbp_ctr_ram.sv
module cbp_ctr_ram
  import cbp_pkg::*;
#(
  parameter int AW  = 10,
  parameter int NRD = 2,
  localparam int DEPTH = 1 << AW
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  ctr_t                   wdata,
  input  logic [NRD-1:0]         re,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output ctr_t [NRD-1:0]         rdata
);

  // One simple-dual-port copy per reader; all copies share the write.
  generate
    for (genvar g = 0; g < NRD; g++) begin : g_copy
      ctr_t mem [DEPTH];
      ctr_t q;

      always_ff @(posedge clk) begin
        if (we)    mem[waddr] <= wdata;
        if (re[g]) q <= mem[raddr[g]];
      end

      assign rdata[g] = q;
    end
  endgenerate

endmodule

// File: rtl/cbp_update.sv
module cbp_update
  import cbp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_fire,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  input  ctr_t             rd_data,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  output logic             we,
  output logic [IDX_W-1:0] waddr,
  output ctr_t             wdata,
  output logic             init_done
);

  // Initialisation walk
  logic             init_busy;
  logic [IDX_W-1:0] init_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_busy <= 1'b1;
      init_ptr  <= '0;
    end else if (init_busy) begin
      init_ptr <= init_ptr + 1'b1;
      if (init_ptr == '1) init_busy <= 1'b0;
    end
  end

  assign init_done = !init_busy;

  // Stage 1: read issued; stage 2: modify and write
  assign rd_en   = upd_fire;
  assign rd_addr = upd_idx;

  logic             s1_valid;
  logic [IDX_W-1:0] s1_idx;
  logic             s1_taken;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= upd_fire;
    s1_idx   <= upd_idx;
    s1_taken <= upd_taken;
  end

  // Last write, kept to bypass the read-before-write hole
  logic             lw_valid;
  logic [IDX_W-1:0] lw_idx;
  ctr_t             lw_data;
  ctr_t             cur;
  ctr_t             nxt;

  always_comb begin
    cur = (lw_valid && lw_idx == s1_idx) ? lw_data : rd_data;
    nxt = ctr_next(cur, s1_taken);
  end

  always_ff @(posedge clk) begin
    if (rst) lw_valid <= 1'b0;
    else     lw_valid <= s1_valid && !init_busy;
    lw_idx  <= s1_idx;
    lw_data <= nxt;
  end

  assign we    = init_busy | s1_valid;
  assign waddr = init_busy ? init_ptr : s1_idx;
  assign wdata = init_busy ? CTR_WNT : nxt;

  // Taken never leaves a counter at strongly not-taken (R2)
  assert_taken_up_R2: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_taken) |=> (lw_data != CTR_SNT));

  // Not-taken never leaves a counter at strongly taken (R2)
  assert_nt_down_R2: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_taken) |=> (lw_data != CTR_ST));

  // No update enters the pipe while the walk runs (R8)
  assert_no_upd_in_init_R8: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> !init_busy);

  // Walk ends only after the last entry (R8)
  assert_walk_full_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(init_busy) |-> $past(init_ptr) == '1);

endmodule

// File: rtl/corr_branch_pred.sv
module corr_branch_pred
  import cbp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int ADDR_LSB = 2,
  parameter int SET_BITS = 8,
  parameter int HIST_LEN = 2,
  localparam int HW    = (HIST_LEN > 0) ? HIST_LEN : 1,
  localparam int IDX_W = SET_BITS + HIST_LEN
) (
  input  logic            clk,
  input  logic            rst,
  output logic            init_done,
  input  logic            pred_valid,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_out_valid,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  logic [HW-1:0]    ghist;
  logic [IDX_W-1:0] pidx;
  logic [IDX_W-1:0] uidx;
  logic             pred_fire;
  logic             upd_fire;

  assign pred_fire = pred_valid & init_done;
  assign upd_fire  = upd_valid & init_done;

  cbp_index #(.PC_W(PC_W), .ADDR_LSB(ADDR_LSB), .SET_BITS(SET_BITS), .HIST_LEN(HIST_LEN))
    u_pidx (.pc(pred_pc), .hist(ghist), .idx(pidx));

  cbp_index #(.PC_W(PC_W), .ADDR_LSB(ADDR_LSB), .SET_BITS(SET_BITS), .HIST_LEN(HIST_LEN))
    u_uidx (.pc(upd_pc), .hist(ghist), .idx(uidx));

  cbp_history #(.HIST_LEN(HIST_LEN)) u_hist (
    .clk(clk), .rst(rst), .shift_en(upd_fire), .outcome(upd_taken), .hist(ghist)
  );

  logic             u_rd_en;
  logic [IDX_W-1:0] u_rd_addr;
  logic             t_we;
  logic [IDX_W-1:0] t_waddr;
  ctr_t             t_wdata;
  ctr_t [1:0]       t_rdata;

  cbp_ctr_ram #(.AW(IDX_W), .NRD(2)) u_ram (
    .clk(clk), .we(t_we), .waddr(t_waddr), .wdata(t_wdata),
    .re({u_rd_en, pred_fire}), .raddr({u_rd_addr, pidx}), .rdata(t_rdata)
  );

  cbp_update #(.IDX_W(IDX_W)) u_upd (
    .clk(clk), .rst(rst), .upd_fire(upd_fire), .upd_idx(uidx), .upd_taken(upd_taken),
    .rd_data(t_rdata[1]), .rd_en(u_rd_en), .rd_addr(u_rd_addr),
    .we(t_we), .waddr(t_waddr), .wdata(t_wdata), .init_done(init_done)
  );

  always_ff @(posedge clk) begin
    if (rst) pred_out_valid <= 1'b0;
    else     pred_out_valid <= pred_fire;
  end

  assign pred_taken = ctr_dir(t_rdata[0]);

  // Accepted request answers in the next cycle (R1)
  assert_pred_lat_R1: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && init_done) |=> pred_out_valid);

  // Requests during the walk give no result (R8)
  assert_init_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !init_done |=> !pred_out_valid);

  // Once ready, stays ready until reset (R8)
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

endmodule

// File: tb/sim_corr_branch_pred.sv
module sim_corr_branch_pred;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  always #10 clk = ~clk;

  // Default instance
  logic        init_done, pred_valid, pred_out_valid, pred_taken, upd_valid, upd_taken;
  logic [31:0] pred_pc, upd_pc;

  corr_branch_pred u0 (
    .clk(clk), .rst(rst), .init_done(init_done),
    .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_out_valid(pred_out_valid), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  // History-free instance
  logic        u1_init_done, u1_pv, u1_ov, u1_pt, u1_uv, u1_ut;
  logic [31:0] u1_ppc, u1_upc;

  corr_branch_pred #(.SET_BITS(4), .HIST_LEN(0)) u1 (
    .clk(clk), .rst(rst), .init_done(u1_init_done),
    .pred_valid(u1_pv), .pred_pc(u1_ppc),
    .pred_out_valid(u1_ov), .pred_taken(u1_pt),
    .upd_valid(u1_uv), .upd_pc(u1_upc), .upd_taken(u1_ut)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  int          mdl [1024];
  int unsigned mh = 0;
  bit          exp_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkpc(input int set, input int hi);
    return (32'(hi) << 10) | (32'(set) << 2);
  endfunction

  function automatic int midx(input logic [31:0] pc);
    return (int'(pc[9:2]) << 2) | int'(mh);
  endfunction

  task automatic do_pred(input logic [31:0] pc, input string tag);
    exp_q.push_back(mdl[midx(pc)] >= 2);
    tag_q.push_back(tag);
    pred_valid = 1'b1;
    pred_pc    = pc;
    @(negedge clk);
    pred_valid = 1'b0;
  endtask

  task automatic upd_drive(input logic [31:0] pc, input bit t);
    int i;
    i = midx(pc);
    if (t) mdl[i] = (mdl[i] == 3) ? 3 : mdl[i] + 1;
    else   mdl[i] = (mdl[i] == 0) ? 0 : mdl[i] - 1;
    mh = ((mh << 1) | int'(t)) & 3;
    upd_valid = 1'b1;
    upd_pc    = pc;
    upd_taken = t;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_upd(input logic [31:0] pc, input bit t);
    upd_drive(pc, t);
    @(negedge clk);
  endtask

  task automatic u1_upd(input logic [31:0] pc, input bit t);
    u1_uv = 1'b1; u1_upc = pc; u1_ut = t;
    @(negedge clk);
    u1_uv = 1'b0;
    @(negedge clk);
  endtask

  task automatic u1_pred(input logic [31:0] pc, input bit exp, input string tag);
    u1_pv = 1'b1; u1_ppc = pc;
    @(negedge clk);
    u1_pv = 1'b0;
    chk(u1_ov == 1'b1, {tag, " valid"}, int'(u1_ov), 1);
    chk(u1_pt == exp, tag, int'(u1_pt), int'(exp));
  endtask

  // Monitor: compare each result against the queued expectation
  always @(negedge clk) begin
    bit    e;
    string t;
    if (!rst && pred_out_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected result", 1, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(pred_taken == e, t, int'(pred_taken), int'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [31:0] P = 32'h0000_0014; // set 5
  localparam logic [31:0] Q = 32'h0000_0024; // set 9
  localparam logic [31:0] RB = 32'h0000_0050; // set 20

  initial begin
    pred_valid = 0; pred_pc = 0; upd_valid = 0; upd_pc = 0; upd_taken = 0;
    u1_pv = 0; u1_ppc = 0; u1_uv = 0; u1_upc = 0; u1_ut = 0;
    for (int i = 0; i < 1024; i++) mdl[i] = 1;

    repeat (3) @(negedge clk);
    chk(init_done == 1'b0, "R8 init_done low in reset", int'(init_done), 0);
    chk(pred_out_valid == 1'b0, "R8 no result in reset", int'(pred_out_valid), 0);
    rst = 1'b0;

    // Requests during the walk are ignored (R8)
    pred_valid = 1; pred_pc = P; upd_valid = 1; upd_pc = P; upd_taken = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(pred_out_valid == 1'b0, "R8 no result during walk", int'(pred_out_valid), 0);
      chk(init_done == 1'b0, "R8 walk still running", int'(init_done), 0);
    end
    pred_valid = 0; upd_valid = 0;
    while (!init_done) @(negedge clk);
    @(negedge clk);

    // Fresh counters read weakly not-taken
    do_pred(P, "R1 fresh counter");
    do_pred(Q, "R8 fresh counter");

    // Pre-shift history indexes the update (R6)
    do_upd(P, 1);
    do_upd(Q, 0);
    do_upd(Q, 0);
    do_pred(P, "R6 trained under history 00");
    do_pred(mkpc(6, 0), "R7 neighbour set untouched");
    do_pred(P | 32'h3, "R4 low PC bits ignored");
    do_pred(P | (32'h3 << 10), "R4 high PC bits alias");

    // Different history, different counter (R4)
    do_upd(Q, 1);
    do_upd(Q, 1);
    do_pred(P, "R4 history 11 selects other counter");

    // Saturation (R2)
    for (int k = 0; k < 5; k++) do_upd(P, 1);
    do_pred(P, "R2 saturated taken");

    // Hysteresis (R3)
    do_upd(P, 0);
    do_upd(Q, 1);
    do_upd(Q, 1);
    do_pred(P, "R3 one miss keeps prediction");
    do_upd(P, 0);
    do_upd(Q, 1);
    do_upd(Q, 1);
    do_pred(P, "R3 second miss flips prediction");

    // Back-to-back updates to one counter (R9)
    upd_drive(RB, 1);
    upd_drive(RB, 1);
    @(negedge clk);
    do_upd(RB, 0);
    do_upd(Q, 1);
    do_upd(Q, 1);
    do_pred(RB, "R9 both back-to-back updates applied");

    // History shifting checked through reference model (R5)
    do_upd(Q, 0);
    do_upd(P, 1);
    do_pred(P, "R5 history 01 counter");
    do_pred(RB, "R5 history 01 other set");

    // Random mix against the model
    for (int k = 0; k < 300; k++) begin
      logic [31:0] pc;
      pc = mkpc($urandom_range(30, 35), $urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) do_upd(pc, 1'($urandom_range(0, 1)));
      else do_pred(pc, "R2 random mix");
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all requests answered", exp_q.size(), 0);

    // Per-address configuration (R10)
    u1_pred(32'h4, 1'b0, "R10 fresh");
    u1_upd(32'h4, 1);
    u1_upd(32'h8, 0);
    u1_pred(32'h4, 1'b1, "R10 taken after one update");
    u1_upd(32'h4, 0);
    u1_pred(32'h4, 1'b0, "R10 back to weak not-taken");
    u1_upd(32'h4, 1);
    u1_upd(32'h4, 1);
    u1_upd(32'h4, 1);
    u1_upd(32'h8, 1);
    u1_upd(32'h4, 0);
    u1_pred(32'h4, 1'b1, "R10 independent of other branch");
    u1_pred(32'h8, 1'b0, "R10 other branch own counter");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule